// File: doc/BRIEF.md
# Ring-Buffer Delay-Memory Address Generator

This block forms the byte address that an audio signal processor uses when it reads from or writes to its external delay-line memory. Each program step gives it a base word address, which is already fetched from a base-address table. It also gives an optional offset taken from an offset register, an optional increment of one, and a mode flag. The mode flag chooses between ring addressing and table addressing. In ring mode the word address moves with a counter that steps down once per audio sample. Delay taps written at fixed offsets therefore slide through a circular buffer, whose size is set by a power-of-two length mask. In table mode the counter is left out, so fixed lookup data can be reached directly.

Memory traffic is allowed only on odd-numbered steps. When a step asks to both write and read, the block issues the write first and the read in the next cycle. It holds off the next step for that one extra cycle. Every accepted step also produces two slot indices into a four-entry holding buffer. The first tells where the returned read data will land. The second tells which held entry a later input-write copy should take. The memory itself and the sample format conversion lie outside this block.

Top module: `ring_addr_gen`

## Requirements
- R1: The word sum is `baseAddr`, plus the low 12 bits of `adrsOfs` when `addOfs` is 1, plus 1 when `nextAddr` is 1.
- R2: With `tableMode` 0, `ringCount` is added to the word sum and the result is ANDed with `ringMask` (WORD_W bits) to give the word address.
- R3: With `tableMode` 1, the word sum is truncated to its low 16 bits (WORD_W) and `ringCount` has no effect on the address.
- R4: `memAddr` equals (word address × 2 + `ringBase`) truncated to MEM_AW bits. It is registered on every accepted step and appears one clock after the accepting edge.
- R5: A step is accepted when `stepValid` and `stepReady` are both 1. A request (`memReq`=1 one clock later) is made only when bit 0 of `stepIdx` is 1 and `wantRead` or `wantWrite` is 1. `memWe`=1 marks a write. An even step never produces a request.
- R6: An odd step with both `wantRead` and `wantWrite` gives a write cycle (`memReq`=1, `memWe`=1, `stepReady`=0), followed by a read cycle (`memReq`=1, `memWe`=0) at the same `memAddr`. After that, `stepReady` returns to 1.
- R7: On every accepted step, `rdSlot` becomes (`stepIdx` + 2) mod 4 and `copySlot` becomes `stepIdx` mod 4, one clock after the accepting edge.
- R8: On a clock with `sampleEnd`=1, `ringCount` becomes `ringMask`+1 if it is 0 or 1, and otherwise becomes `ringCount`−1. It is WORD_W+1 bits wide and does not change without `sampleEnd`.
- R9: After reset, `memReq`, `memWe`, `memAddr`, `rdSlot`, `copySlot` and `ringCount` are 0, and `stepReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepValid | input | 1 | A program step is presented |
| stepReady | output | 1 | Block can accept a step this cycle |
| stepIdx | input | STEP_W | Step number within the program |
| wantRead | input | 1 | Step reads delay memory |
| wantWrite | input | 1 | Step writes delay memory |
| addOfs | input | 1 | Add the 12-bit offset register value |
| nextAddr | input | 1 | Add one word |
| tableMode | input | 1 | Bypass ring addressing |
| baseAddr | input | WORD_W | Base word address from the table |
| adrsOfs | input | WORD_W | Address-offset register |
| ringMask | input | WORD_W | Ring length mask (length − 1) |
| ringBase | input | MEM_AW | Ring base, byte address |
| sampleEnd | input | 1 | End-of-sample strobe for the ring counter |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | MEM_AW | Byte address of the request |
| rdSlot | output | 2 | Holding slot for returned read data |
| copySlot | output | 2 | Holding slot for an input-write copy |
| ringCount | output | WORD_W+1 | Ring counter |

## Verification
Address, request and slot results are due at the first clock edge after the accepting edge. The bench drives on the falling edge and checks on the next falling edge. For a combined write-and-read step, the read half is checked one falling edge later, at the same address. A counter update is checked on the falling edge right after the edge that saw `sampleEnd`. The expected counter value comes from a bench model that uses the same reload rule. The sweeps cover several ring masks, every flag combination and odd and even steps, so table and ring addressing are both checked at many counter positions.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address and slots
    logic req;      // drive a memory request next cycle
    logic we;       // that request is a write
    logic tick;     // end of sample, step the ring counter
  } strobe_t;
endpackage

// File: rtl/ring_addr_ctrl.sv
module ring_addr_ctrl
  import ring_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    stepValid,
  input  logic    stepOdd,
  input  logic    wantRead,
  input  logic    wantWrite,
  input  logic    sampleEnd,
  output logic    stepReady,
  output strobe_t strobe
);
  logic pendRead;
  logic accept;
  logic memStep;

  assign stepReady = !pendRead;
  assign accept    = stepValid && stepReady;
  assign memStep   = accept && stepOdd;

  always_comb begin
    strobe.capture = accept;
    strobe.req     = (memStep && (wantRead || wantWrite)) || pendRead;
    strobe.we      = memStep && wantWrite;
    strobe.tick    = sampleEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendRead <= 1'b0;
    else       pendRead <= memStep && wantRead && wantWrite;
  end
endmodule

// File: rtl/ring_addr_dp.sv
module ring_addr_dp
  import ring_addr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 12,
  parameter int MEM_AW = 21,
  parameter int STEP_W = 7,
  localparam int CT_W  = WORD_W + 1,
  localparam int SUM_W = WORD_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              addOfs,
  input  logic              nextAddr,
  input  logic              tableMode,
  input  logic [WORD_W-1:0] baseAddr,
  input  logic [WORD_W-1:0] adrsOfs,
  input  logic [WORD_W-1:0] ringMask,
  input  logic [MEM_AW-1:0] ringBase,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [1:0]        rdSlot,
  output logic [1:0]        copySlot,
  output logic [CT_W-1:0]   ringCount
);
  logic [SUM_W-1:0]  wordSum;
  logic [SUM_W-1:0]  ringSum;
  logic [WORD_W-1:0] wordAddr;
  logic [MEM_AW-1:0] byteAddr;
  logic [CT_W-1:0]   countNext;

  always_comb begin
    wordSum = SUM_W'(baseAddr)
            + (addOfs ? SUM_W'(adrsOfs[OFS_W-1:0]) : '0)
            + SUM_W'(nextAddr);
    ringSum = wordSum + SUM_W'(ringCount);
    if (tableMode) wordAddr = wordSum[WORD_W-1:0];
    else           wordAddr = ringSum[WORD_W-1:0] & ringMask;
    byteAddr = MEM_AW'({wordAddr, 1'b0}) + ringBase;
  end

  always_comb begin
    if (ringCount <= CT_W'(1)) countNext = {1'b0, ringMask} + CT_W'(1);
    else                       countNext = ringCount - CT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq    <= 1'b0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      rdSlot    <= '0;
      copySlot  <= '0;
      ringCount <= '0;
    end else begin
      memReq <= strobe.req;
      memWe  <= strobe.we;
      if (strobe.capture) begin
        memAddr  <= byteAddr;
        rdSlot   <= stepIdx[1:0] + 2'd2;
        copySlot <= stepIdx[1:0];
      end
      if (strobe.tick) ringCount <= countNext;
    end
  end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
  import ring_addr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 12,
  parameter int MEM_AW = 21,
  parameter int STEP_W = 7,
  localparam int CT_W  = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepValid,
  output logic              stepReady,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              wantRead,
  input  logic              wantWrite,
  input  logic              addOfs,
  input  logic              nextAddr,
  input  logic              tableMode,
  input  logic [WORD_W-1:0] baseAddr,
  input  logic [WORD_W-1:0] adrsOfs,
  input  logic [WORD_W-1:0] ringMask,
  input  logic [MEM_AW-1:0] ringBase,
  input  logic              sampleEnd,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [1:0]        rdSlot,
  output logic [1:0]        copySlot,
  output logic [CT_W-1:0]   ringCount
);
  strobe_t strobe;

  ring_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .stepOdd(stepIdx[0]),
    .wantRead(wantRead), .wantWrite(wantWrite), .sampleEnd(sampleEnd),
    .stepReady(stepReady), .strobe(strobe)
  );

  ring_addr_dp #(.WORD_W(WORD_W), .OFS_W(OFS_W), .MEM_AW(MEM_AW), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .addOfs(addOfs), .nextAddr(nextAddr), .tableMode(tableMode),
    .baseAddr(baseAddr), .adrsOfs(adrsOfs), .ringMask(ringMask), .ringBase(ringBase),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .rdSlot(rdSlot), .copySlot(copySlot), .ringCount(ringCount)
  );
endmodule

// File: rtl/ring_addr_chk.sv
module ring_addr_chk #(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 12,
  parameter int MEM_AW = 21,
  parameter int STEP_W = 7,
  localparam int CT_W  = WORD_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              stepValid,
  input logic              stepReady,
  input logic [STEP_W-1:0] stepIdx,
  input logic              wantRead,
  input logic              wantWrite,
  input logic [WORD_W-1:0] ringMask,
  input logic              sampleEnd,
  input logic              memReq,
  input logic              memWe,
  input logic [MEM_AW-1:0] memAddr,
  input logic [1:0]        rdSlot,
  input logic [1:0]        copySlot,
  input logic [CT_W-1:0]   ringCount
);
  assert_even_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepReady && !stepIdx[0]) |=> !memReq);

  assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepReady && stepIdx[0] && wantRead && wantWrite)
      |=> (memReq && memWe && !stepReady) ##1 (memReq && !memWe && $stable(memAddr)));

  assert_slots_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepReady)
      |=> (rdSlot == $past(stepIdx[1:0]) + 2'd2) && (copySlot == $past(stepIdx[1:0])));

  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEnd && ringCount > CT_W'(1)) |=> ringCount == $past(ringCount) - CT_W'(1));

  assert_count_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEnd && ringCount <= CT_W'(1)) |=> ringCount == {1'b0, $past(ringMask)} + CT_W'(1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEnd |=> $stable(ringCount));
endmodule

bind ring_addr_gen ring_addr_chk #(.WORD_W(WORD_W), .OFS_W(OFS_W), .MEM_AW(MEM_AW), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/tb_ring_addr_gen.sv
module tb_ring_addr_gen;
  localparam int PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int MEM_AW = 21;
  localparam int STEP_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepValid = 1'b0;
  logic stepReady;
  logic [STEP_W-1:0] stepIdx = '0;
  logic wantRead = 1'b0, wantWrite = 1'b0;
  logic addOfs = 1'b0, nextAddr = 1'b0, tableMode = 1'b0;
  logic [WORD_W-1:0] baseAddr = '0, adrsOfs = '0, ringMask = '0;
  logic [MEM_AW-1:0] ringBase = '0;
  logic sampleEnd = 1'b0;
  logic memReq, memWe;
  logic [MEM_AW-1:0] memAddr;
  logic [1:0] rdSlot, copySlot;
  logic [WORD_W:0] ringCount;

  int nChecks = 0;
  int nFails = 0;
  longint ctModel = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ring_addr_gen dut (.*);

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  function automatic longint expAddr(longint base, longint ofs, bit aofs, bit nx,
                                     bit tbl, longint mask, longint ct, longint rb);
    longint w;
    w = base + (aofs ? (ofs & 'hFFF) : 0) + (nx ? 1 : 0);
    if (tbl) w = w & 'hFFFF;
    else     w = (w + ct) & mask;
    return ((w << 1) + rb) & ((longint'(1) << MEM_AW) - 1);
  endfunction

  task automatic tick();
    @(negedge clk);
    sampleEnd = 1'b1;
    @(negedge clk);
    sampleEnd = 1'b0;
    if (ctModel <= 1) ctModel = longint'(ringMask) + 1;
    else              ctModel = ctModel - 1;
    check("R8 ringCount", ringCount, ctModel);
  endtask

  task automatic doStep(int step, bit rd, bit wr, bit aofs, bit nx, bit tbl,
                        longint base, longint ofs, longint rb);
    longint ea;
    bit odd;
    @(negedge clk);
    stepIdx = STEP_W'(step);
    wantRead = rd; wantWrite = wr;
    addOfs = aofs; nextAddr = nx; tableMode = tbl;
    baseAddr = WORD_W'(base); adrsOfs = WORD_W'(ofs); ringBase = MEM_AW'(rb);
    stepValid = 1'b1;
    ea = expAddr(base, ofs, aofs, nx, tbl, longint'(ringMask), ctModel, rb);
    odd = step[0];
    @(negedge clk);
    stepValid = 1'b0;
    // R1 R2 R3 R4: address one edge after acceptance
    check(tbl ? "R3 R4 memAddr table" : "R1 R2 R4 memAddr ring", memAddr, ea);
    check("R7 rdSlot", rdSlot, (step + 2) % 4);
    check("R7 copySlot", copySlot, step % 4);
    check("R5 memReq", memReq, odd && (rd || wr));
    if (odd && (rd || wr)) check("R5 memWe", memWe, wr);
    if (odd && rd && wr) begin
      check("R6 stepReady low", stepReady, 0);
      @(negedge clk);
      check("R6 read phase memReq", memReq, 1);
      check("R6 read phase memWe", memWe, 0);
      check("R6 read phase memAddr", memAddr, ea);
      check("R6 stepReady back", stepReady, 1);
    end else begin
      check("R6 stepReady", stepReady, 1);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    longint masks [3] = '{'h7, 'h3F, 'hFFFF};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 memReq", memReq, 0);
    check("R9 memWe", memWe, 0);
    check("R9 memAddr", memAddr, 0);
    check("R9 rdSlot", rdSlot, 0);
    check("R9 copySlot", copySlot, 0);
    check("R9 ringCount", ringCount, 0);
    check("R9 stepReady", stepReady, 1);

    for (int m = 0; m < 3; m++) begin
      ringMask = WORD_W'(masks[m]);
      for (int t = 0; t < 10; t++) begin
        tick();
        for (int f = 0; f < 8; f++) begin
          for (int s = 0; s < 4; s++) begin
            int rw;
            longint base, ofs, rb;
            rw   = (f + s + t) % 4;
            base = (masks[m] * 37 + f * 1111 + s * 7 + t * 4093) & 'hFFFF;
            ofs  = 'hF000 | ((t * 293 + f * 17) & 'hFFF);
            rb   = (m == 2) ? 'h1FFF00 + t * 16 : 'h1000 * (t + 1);
            doStep(s + 4 * t, rw[0], rw[1], f[0], f[1], f[2], base, ofs, rb);
          end
        end
      end
      // R8: hold when sampleEnd stays low
      repeat (3) @(negedge clk);
      check("R8 ringCount hold", ringCount, ctModel);
    end

    finished = 1'b1;
    summary();
  end
endmodule